// File: doc/BRIEF.md
# Crossbar Barrel Shifter

This block moves a data word by any distance from zero to one less than the word width in a single pass. It supports four operations: shift left with zero fill, shift right with zero fill, shift right with sign fill, and rotate right. It also returns the shifter carry that a processor datapath feeds into its flags. The result and the carry are registered, so they appear one clock after the operands are presented.

Inside, the shifter works as a switch matrix. For each possible distance there is a "right" diagonal and a "left" diagonal. A decoder turns the distance and the operation into diagonal enables. Each output bit then takes the input bit that an enabled diagonal points at. An output bit that no enabled diagonal reaches reads zero, and that is where the zero fill of plain shifts comes from. A rotate enables two complementary diagonals at the same time. Sign fill is a separate mask, ORed onto the zero-filled matrix output.

Top module: `xbar_shifter`

## Requirements
- R1: After reset `result_o` and `carry_o` read 0. Every result and carry appears on the outputs exactly one rising clock edge after the matching inputs are sampled, for every distance from 0 to WIDTH-1.
- R2: `kind_i` selects the operation: 2'b00 shift left, 2'b01 logical shift right, 2'b10 arithmetic shift right, 2'b11 rotate right. Apart from a rotate by a nonzero distance, each output bit is taken from at most one input bit through a single diagonal.
- R3: Shift left by k gives `operand << k`, and the k lowest result bits are 0.
- R4: Logical shift right by k gives `operand >> k`, and the k highest result bits are 0.
- R5: Arithmetic shift right by k gives `operand >> k`, with the k highest result bits equal to operand bit WIDTH-1.
- R6: Rotate right by a nonzero k enables exactly one right diagonal and exactly one left diagonal. The result is `(operand >> k) | (operand << (WIDTH-k))`, so no bit is lost.
- R7: With a distance of 0, every operation returns the operand unchanged and `carry_o` equals `carry_i`.
- R8: With a nonzero distance k, `carry_o` is operand bit WIDTH-k for shift left. For the other three operations it is operand bit k-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| operand_i | input | WIDTH | Word to shift |
| amount_i | input | $clog2(WIDTH) | Shift distance |
| kind_i | input | 2 | Operation select (see R2) |
| carry_i | input | 1 | Carry returned when the distance is 0 |
| result_o | output | WIDTH | Registered shifted word |
| carry_o | output | 1 | Registered shifter carry |

## Verification
A wrong diagonal enable would show up on `result_o` one clock after the faulty inputs: bits would be displaced, doubled (ORed), or missing. A missing rotate half, for example, would show as zeros where wrapped bits belong. A bad sign-fill mask would corrupt only the upper k bits of arithmetic shifts. A bad carry select would show on `carry_o` in the same cycle. The bench sweeps every operation against every distance on patterned and random words, so any such fault appears within one vector of the offending combination.

// File: rtl/xbar_shifter_pkg.sv
package xbar_shifter_pkg;

    typedef enum logic [1:0] {
        SH_LSL = 2'b00,
        SH_LSR = 2'b01,
        SH_ASR = 2'b10,
        SH_ROR = 2'b11
    } shift_kind_e;

endpackage

// File: rtl/xbar_diag_decode.sv
module xbar_diag_decode
    import xbar_shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [AMT_W-1:0] amount_i,
    input  shift_kind_e      kind_i,
    output logic [WIDTH-1:0] rdiag_o,
    output logic [WIDTH-1:0] ldiag_o
);

    // rdiag_o[k]: output j takes input j+k; ldiag_o[k]: output j takes input j-k
    always_comb begin
        int amt;
        amt = int'(amount_i);
        for (int k = 0; k < WIDTH; k++) begin
            rdiag_o[k] = (kind_i != SH_LSL) && (amt == k);
            ldiag_o[k] = ((kind_i == SH_LSL) && (amt == k)) ||
                         ((kind_i == SH_ROR) && (amt != 0) && ((WIDTH - amt) == k));
        end
    end

endmodule

// File: rtl/xbar_matrix.sv
module xbar_matrix #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] rdiag_i,
    input  logic [WIDTH-1:0] ldiag_i,
    output logic [WIDTH-1:0] data_o
);

    for (genvar j = 0; j < WIDTH; j++) begin : g_out
        logic [WIDTH-1:0] rterm;
        logic [WIDTH-1:0] lterm;
        for (genvar k = 0; k < WIDTH; k++) begin : g_tap
            if (j + k < WIDTH) begin : g_r
                assign rterm[k] = rdiag_i[k] & data_i[j+k];
            end else begin : g_rz
                assign rterm[k] = 1'b0;
            end
            if (j >= k) begin : g_l
                assign lterm[k] = ldiag_i[k] & data_i[j-k];
            end else begin : g_lz
                assign lterm[k] = 1'b0;
            end
        end
        // a column with no enabled switch stays at zero
        assign data_o[j] = (|rterm) | (|lterm);
    end

endmodule

// File: rtl/xbar_sign_fill.sv
module xbar_sign_fill
    import xbar_shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic [AMT_W-1:0] amount_i,
    input  shift_kind_e      kind_i,
    output logic [WIDTH-1:0] fill_o
);

    always_comb begin
        int amt;
        amt = int'(amount_i);
        for (int j = 0; j < WIDTH; j++) begin
            fill_o[j] = (kind_i == SH_ASR) && data_i[WIDTH-1] && (j >= WIDTH - amt);
        end
    end

endmodule

// File: rtl/xbar_shifter.sv
module xbar_shifter
    import xbar_shifter_pkg::*;
#(
    parameter int WIDTH = 32,
    localparam int AMT_W = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] operand_i,
    input  logic [AMT_W-1:0] amount_i,
    input  logic [1:0]       kind_i,
    input  logic             carry_i,
    output logic [WIDTH-1:0] result_o,
    output logic             carry_o
);

    typedef struct packed {
        logic [WIDTH-1:0] result;
        logic             carry;
    } shift_state_t;

    shift_kind_e      kind;
    logic [WIDTH-1:0] rdiag;
    logic [WIDTH-1:0] ldiag;
    logic [WIDTH-1:0] matrix_out;
    logic [WIDTH-1:0] sign_fill;
    shift_state_t     state_d;
    shift_state_t     state_q;

    assign kind = shift_kind_e'(kind_i);

    xbar_diag_decode #(.WIDTH(WIDTH)) decode_i (
        .amount_i (amount_i),
        .kind_i   (kind),
        .rdiag_o  (rdiag),
        .ldiag_o  (ldiag)
    );

    xbar_matrix #(.WIDTH(WIDTH)) matrix_i (
        .data_i   (operand_i),
        .rdiag_i  (rdiag),
        .ldiag_i  (ldiag),
        .data_o   (matrix_out)
    );

    xbar_sign_fill #(.WIDTH(WIDTH)) fill_i (
        .data_i   (operand_i),
        .amount_i (amount_i),
        .kind_i   (kind),
        .fill_o   (sign_fill)
    );

    always_comb begin
        int amt;
        amt = int'(amount_i);
        state_d.result = matrix_out | sign_fill;
        if (amt == 0) begin
            state_d.carry = carry_i;
        end else if (kind == SH_LSL) begin
            state_d.carry = operand_i[WIDTH-amt];
        end else begin
            state_d.carry = operand_i[amt-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign result_o = state_q.result;
    assign carry_o  = state_q.carry;

    // R2: plain shifts and zero-distance rotates close a single diagonal
    a_r2_single_diagonal: assert property (@(posedge clk) disable iff (!rst_n)
        (kind != SH_ROR || amount_i == '0) |->
            ($countones(rdiag) + $countones(ldiag)) == 1);

    // R6: nonzero rotate closes one right and one left diagonal
    a_r6_rotate_two_diagonals: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SH_ROR && amount_i != '0) |->
            ($countones(rdiag) == 1 && $countones(ldiag) == 1));

    // R6: rotation keeps every set bit
    a_r6_rotate_keeps_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SH_ROR) |=> $countones(result_o) == $countones($past(operand_i)));

    // R7: zero distance is a pass-through with carry_i forwarded
    a_r7_zero_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (amount_i == '0) |=> (result_o == $past(operand_i) && carry_o == $past(carry_i)));

    // R5: the top bit never changes under arithmetic shift
    a_r5_sign_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SH_ASR) |=> result_o[WIDTH-1] == $past(operand_i[WIDTH-1]));

    // R3: a nonzero left shift clears bit 0
    a_r3_low_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SH_LSL && amount_i != '0) |=> result_o[0] == 1'b0);

    // R4: a nonzero logical right shift clears the top bit
    a_r4_top_bit_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (kind == SH_LSR && amount_i != '0) |=> result_o[WIDTH-1] == 1'b0);

endmodule

// File: tb/xbar_shifter_tb_top.sv
module xbar_shifter_tb_top;

    localparam int W = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  operand = '0;
    logic [AW-1:0] amount = '0;
    logic [1:0]    kind = 2'b00;
    logic          cin = 1'b0;
    logic [W-1:0]  result;
    logic          cout;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk; // 50 MHz

    xbar_shifter #(.WIDTH(W)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .operand_i (operand),
        .amount_i  (amount),
        .kind_i    (kind),
        .carry_i   (cin),
        .result_o  (result),
        .carry_o   (cout)
    );

    // Reference: {carry, result}; 00 LSL, 01 LSR, 10 ASR, 11 ROR
    function automatic logic [W:0] model(logic [W-1:0] x, int k, logic [1:0] t, logic c);
        logic [W-1:0] r;
        logic         co;
        case (t)
            2'b00: begin r = x << k; co = (k == 0) ? c : x[W-k]; end
            2'b01: begin r = x >> k; co = (k == 0) ? c : x[k-1]; end
            2'b10: begin r = W'($signed(x) >>> k); co = (k == 0) ? c : x[k-1]; end
            default: begin
                r  = (k == 0) ? x : ((x >> k) | (x << (W - k)));
                co = (k == 0) ? c : x[k-1];
            end
        endcase
        return {co, r};
    endfunction

    function automatic string req_of(int k, logic [1:0] t);
        if (k == 0) return "R7";
        case (t)
            2'b00: return "R2 R3";
            2'b01: return "R4";
            2'b10: return "R5";
            default: return "R6";
        endcase
    endfunction

    // R1: inputs driven at a falling edge, result checked one rising edge later
    task automatic run_vec(logic [W-1:0] x, int k, logic [1:0] t, logic c);
        logic [W:0] exp;
        @(negedge clk);
        operand = x; amount = AW'(k); kind = t; cin = c;
        exp = model(x, k, t, c);
        @(negedge clk);
        checks++;
        if (result !== exp[W-1:0]) begin
            failures++;
            $display("FAIL %s R1 result kind=%0d k=%0d op=%h actual=%h expected=%h",
                     req_of(k, t), t, k, x, result, exp[W-1:0]);
        end
        checks++;
        if (cout !== exp[W]) begin
            failures++;
            $display("FAIL %s carry kind=%0d k=%0d op=%h actual=%b expected=%b",
                     (k == 0) ? "R7" : "R8", t, k, x, cout, exp[W]);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (result !== '0 || cout !== 1'b0) begin
            failures++;
            $display("FAIL R1 reset actual=%h/%b expected=0/0", result, cout);
        end
        rst_n = 1'b1;
        // exhaustive over operation x distance (R2..R8), patterned and random words
        for (int t = 0; t < 4; t++) begin
            for (int k = 0; k < W; k++) begin
                run_vec(32'hFFFF_FFFF, k, 2'(t), 1'b0);
                run_vec(32'h8000_0000, k, 2'(t), 1'b1);
                run_vec(32'h0000_0001, k, 2'(t), 1'b0);
                run_vec(32'h0000_0000, k, 2'(t), 1'b1);
                run_vec(32'hA5C3_0F96, k, 2'(t), 1'b0);
                for (int n = 0; n < 6; n++) begin
                    run_vec($urandom, k, 2'(t), 1'($urandom));
                end
            end
        end
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule